// File: doc/BRIEF.md
# DRAM Refresh Address Counter

This block holds the address that the next refresh cycle of a multi-bank DRAM controller will use, and moves it forward by one after each refresh completes. The address is one chained counter. The row field is the least significant part, the column field comes next, and the bank field is on top. When the row field wraps, it carries into the column field, and a column wrap carries into the bank field. Refresh timing, strobe generation and arbitration against accesses are handled elsewhere. This block only supplies the address and steps it.

A synchronous clear returns the counter to zero so that a burst refresh can start from the first row. The upper bits of the row field are also driven out as progress flags. Logic outside the block can watch them to decide when a burst has covered enough rows. A test select divides the counter into a low segment and a high segment. Both segments advance on every step and no carry passes between them, so the upper fields are exercised in far fewer refresh cycles.

Top module: `rfa_counter`

## Requirements
- R1: A synchronous active-low reset, sampled on a rising clock edge, sets the row, column and bank outputs and every progress flag to zero.
- R2: With the test select low, each single-cycle step pulse adds one to the concatenation {bank, column, row}, with row in the least significant position. The new value appears on the outputs one clock edge after the pulse.
- R3: In a cycle with neither a step pulse nor a clear, all outputs keep their values.
- R4: A clear pulse makes row, column and bank all zero on the following clock edge.
- R5: When a clear and a step pulse occur in the same cycle, the clear wins and the counter becomes zero, not one.
- R6: Progress flag k equals row bit PROG_BASE+k, so flag 0 rises once 2^PROG_BASE rows have been stepped after a clear.
- R7: With the test select high, the low SPLIT_LO_W bits of {bank, column, row} and the remaining high bits each add one per step. Each segment wraps on its own and no carry passes from the low segment into the high segment.
- R8: The counter wraps silently. The all-ones value steps to all zeros and the bank field goes from its maximum back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| refresh_done | input | 1 | Single-cycle pulse after the last refresh strobe of a cycle is released |
| burst_clear | input | 1 | Synchronous clear to zero; has priority over refresh_done |
| split_test | input | 1 | 1 selects the split two-segment count, 0 the normal chained count |
| row_addr | output | ROW_W | Row field of the refresh address |
| col_addr | output | COL_W | Column field of the refresh address |
| bank_addr | output | BANK_W | Bank field of the refresh address |
| rows_done | output | ROW_W-PROG_BASE | Progress flags taken from the upper row bits |

## Verification
The bench works on a reduced configuration and steps through the complete counter range, so every row-to-column and column-to-bank carry is exercised. So is the final all-ones-to-zero wrap. A design with the fields in the wrong order, or a carry that goes missing, would show a wrong column or bank on the first row wrap. A design that raised an error or stuck on the bank wrap would not return to zero. Clear is also sent in the same cycle as a step: if the priority were reversed, the counter would read one instead of zero. In split mode the low segment wraps, and a carry that leaks into the high segment would show up as an extra step there. Idle cycles placed between steps catch a counter that moves without a pulse.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  typedef enum logic {
    CNT_CHAINED = 1'b0,
    CNT_SPLIT   = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/rfa_next.sv
module rfa_next
  import rfa_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LO_W  = 13
) (
  input  logic [CNT_W-1:0] cur,
  input  cnt_mode_e        mode,
  output logic [CNT_W-1:0] nxt,
  output logic             lo_wrap
);
  localparam int HI_W = CNT_W - LO_W;

  function automatic logic [CNT_W-1:0] f_chained(input logic [CNT_W-1:0] v);
    return v + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [LO_W-1:0] f_lo_inc(input logic [LO_W-1:0] v);
    return v + {{(LO_W-1){1'b0}}, 1'b1};
  endfunction

  assign lo_wrap = &cur[LO_W-1:0];

  generate
    if (HI_W > 0) begin : g_split
      function automatic logic [HI_W-1:0] f_hi_inc(input logic [HI_W-1:0] v);
        return v + {{(HI_W-1){1'b0}}, 1'b1};
      endfunction
      logic [CNT_W-1:0] split_val;
      assign split_val = {f_hi_inc(cur[CNT_W-1:LO_W]), f_lo_inc(cur[LO_W-1:0])};
      assign nxt = (mode == CNT_SPLIT) ? split_val : f_chained(cur);
    end else begin : g_nosplit
      assign nxt = f_chained(cur);
    end
  endgenerate
endmodule

// File: rtl/rfa_state.sv
module rfa_state
  import rfa_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LO_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] nxt,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE    = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [LO_W-1:0]  LO_ONE = {{(LO_W-1){1'b0}}, 1'b1};

  logic do_clear, do_step;
  assign do_clear = clr;
  assign do_step  = step & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (do_clear) cnt_q <= '0;
    else if (do_step)  cnt_q <= nxt;
  end

  // R4: a clear empties the counter on the next edge
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R5: a clear in the same cycle as a step still gives zero
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && step) |=> (cnt_q == '0));

  // R3: no pulse, no motion
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(cnt_q));

  // R2/R8: the chained count moves by exactly one, modulo full width
  p_chain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && mode == CNT_CHAINED) |=> (cnt_q == $past(cnt_q) + ONE));

  // R7: the low segment moves by one on its own in split mode
  p_split_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && mode == CNT_SPLIT) |=>
      (cnt_q[LO_W-1:0] == $past(cnt_q[LO_W-1:0]) + LO_ONE));
endmodule

// File: rtl/rfa_fields.sv
module rfa_fields #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int BANK_W    = 2,
  parameter int PROG_BASE = 7
) (
  input  logic [BANK_W+COL_W+ROW_W-1:0] cnt,
  output logic [ROW_W-1:0]              row,
  output logic [COL_W-1:0]              col,
  output logic [BANK_W-1:0]             bank,
  output logic [ROW_W-PROG_BASE-1:0]    prog
);
  localparam int PROG_W = ROW_W - PROG_BASE;

  assign row  = cnt[ROW_W-1:0];
  assign col  = cnt[ROW_W+COL_W-1:ROW_W];
  assign bank = cnt[ROW_W+COL_W+BANK_W-1:ROW_W+COL_W];

  generate
    for (genvar k = 0; k < PROG_W; k++) begin : g_prog
      assign prog[k] = row[PROG_BASE+k];
    end
  endgenerate
endmodule

// File: rtl/rfa_counter.sv
module rfa_counter
  import rfa_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 11,
  parameter int BANK_W     = 2,
  parameter int SPLIT_LO_W = 13,
  parameter int PROG_BASE  = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       refresh_done,
  input  logic                       burst_clear,
  input  logic                       split_test,
  output logic [ROW_W-1:0]           row_addr,
  output logic [COL_W-1:0]           col_addr,
  output logic [BANK_W-1:0]          bank_addr,
  output logic [ROW_W-PROG_BASE-1:0] rows_done
);
  localparam int CNT_W = ROW_W + COL_W + BANK_W;

  cnt_mode_e        mode;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             lo_wrap;

  assign mode = split_test ? CNT_SPLIT : CNT_CHAINED;

  rfa_next #(.CNT_W(CNT_W), .LO_W(SPLIT_LO_W)) u_next (
    .cur(cnt_q), .mode(mode), .nxt(cnt_nxt), .lo_wrap(lo_wrap)
  );

  rfa_state #(.CNT_W(CNT_W), .LO_W(SPLIT_LO_W)) u_state (
    .clk(clk), .rst_n(rst_n), .step(refresh_done), .clr(burst_clear),
    .mode(mode), .nxt(cnt_nxt), .cnt_q(cnt_q)
  );

  rfa_fields #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W),
               .PROG_BASE(PROG_BASE)) u_fields (
    .cnt(cnt_q), .row(row_addr), .col(col_addr), .bank(bank_addr),
    .prog(rows_done)
  );

  // R7: a low-segment wrap in split mode leaves the high segment one step on, not two
  p_no_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_done && !burst_clear && split_test && lo_wrap) |=>
      (cnt_q[CNT_W-1:SPLIT_LO_W] == $past(cnt_q[CNT_W-1:SPLIT_LO_W]) + 1'b1));
endmodule

// File: tb/sim_rfa_counter.sv
module sim_rfa_counter;
  localparam int RW = 4, CW = 3, BW = 2, LOW = 5, PB = 2;
  localparam int TOT = 1 << (RW + CW + BW);
  localparam int LOM = 1 << LOW;
  localparam int HIM = TOT / LOM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc = 1'b0, clr = 1'b0, tst = 1'b0;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [BW-1:0] bank;
  logic [RW-PB-1:0] prog;

  int checks = 0, fails = 0, m = 0;

  always #2.5 clk = ~clk;

  rfa_counter #(.ROW_W(RW), .COL_W(CW), .BANK_W(BW), .SPLIT_LO_W(LOW),
                .PROG_BASE(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .refresh_done(inc), .burst_clear(clr),
    .split_test(tst), .row_addr(row), .col_addr(col), .bank_addr(bank),
    .rows_done(prog)
  );

  function automatic int nxt_chain(input int v);
    return (v + 1) % TOT;
  endfunction

  function automatic int nxt_split(input int v);
    return (((v / LOM) + 1) % HIM) * LOM + ((v % LOM) + 1) % LOM;
  endfunction

  task automatic check(input string req, input int exp_v);
    int er, ec, eb, ep, act;
    er = exp_v % (1 << RW);
    ec = (exp_v >> RW) % (1 << CW);
    eb = exp_v >> (RW + CW);
    ep = er >> PB;
    act = (int'(bank) << (RW + CW)) | (int'(col) << RW) | int'(row);
    checks++;
    if (row !== er[RW-1:0] || col !== ec[CW-1:0] || bank !== eb[BW-1:0]) begin
      fails++;
      $display("FAIL %s: address actual 0x%0h expected 0x%0h", req, act, exp_v);
    end
    checks++;
    if (prog !== ep[RW-PB-1:0]) begin
      fails++;
      $display("FAIL R6 (%s): progress actual %0d expected %0d", req, prog, ep);
    end
  endtask

  task automatic cycle(input logic i, input logic c, input logic t);
    @(negedge clk);
    inc = i; clr = c; tst = t;
    @(negedge clk);
    inc = 1'b0; clr = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    m = 0;
    check("R1 reset", m);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cycle(1'b0, 1'b0, 1'b0);
      check("R3 idle", m);
    end
    // R2 R8: full chained sweep, through every carry and the final wrap
    for (int i = 0; i < TOT + 8; i++) begin
      cycle(1'b1, 1'b0, 1'b0);
      m = nxt_chain(m);
      check((m == 0) ? "R8 wrap" : "R2 step", m);
      if (i % 37 == 5) begin
        cycle(1'b0, 1'b0, 1'b0);
        check("R3 hold", m);
      end
    end
    cycle(1'b0, 1'b1, 1'b0);
    m = 0;
    check("R4 clear", m);
    for (int i = 0; i < 9; i++) begin
      cycle(1'b1, 1'b0, 1'b0);
      m = nxt_chain(m);
    end
    check("R2 after clear", m);
    cycle(1'b1, 1'b1, 1'b0);
    m = 0;
    check("R5 clear wins", m);
    // R7: split sweep past several low-segment wraps
    for (int i = 0; i < 3 * LOM + 4; i++) begin
      cycle(1'b1, 1'b0, 1'b1);
      m = nxt_split(m);
      check("R7 split", m);
    end
    cycle(1'b0, 1'b0, 1'b1);
    check("R3 hold split", m);
    for (int i = 0; i < 5; i++) begin
      cycle(1'b1, 1'b0, 1'b0);
      m = nxt_chain(m);
      check("R2 back to chained", m);
    end
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    m = 0;
    check("R1 reset mid-run", m);
    rst_n = 1'b1;
    report();
  end
endmodule